// File: doc/BRIEF.md
# SIMT Lane Mask Stack

This block keeps the set of active lanes for one warp of a single-instruction, multiple-thread core while that warp runs nested if-then-else regions. Every lane carries a one-bit predicate. A push opens a region and keeps only the lanes whose predicate is true and that were already active. A complement switches to the else-path, where the lanes that were active when the region opened and had a false predicate run. A pop at the join point brings back the mask that was in force before the region opened. The masks of the enclosing regions are kept in a last-in, first-out store of parameterised depth.

For each lane the issue stage receives an execute enable. A lane whose mask bit is clear treats the instruction issued in that cycle as a no-op. The predicate compare, branch targets and fetch are handled outside this block. Commands arrive on a 2-bit code and act at the next clock edge. A push into a full store, and a pop or complement on an empty one, leave the state as it is and raise a one-cycle flag.

Top module: `lane_mask_stack`

## Requirements
- R1: After synchronous reset the active mask is all ones, the depth is 0, and the overflow and underflow flags are low.
- R2: exec_o equals the active mask when issue_i is 1 and is all zeros when issue_i is 0. It follows the inputs of the same cycle and uses the mask before any command given in that cycle takes effect.
- R3: Command code 2'b01 (push) with depth below DEPTH saves the current mask. After the edge the mask is the old mask ANDed with pred_i and the depth has grown by one.
- R4: Command code 2'b10 (complement) with depth above 0 sets the mask to the most recently saved mask ANDed with the inverse of pred_i. The depth does not change.
- R5: Command code 2'b11 (pop) with depth above 0 restores the most recently saved mask and reduces the depth by one.
- R6: A push while the depth equals DEPTH changes neither the mask nor the depth. overflow_o is 1 for exactly the one cycle after that edge.
- R7: A pop or complement while the depth is 0 changes neither the mask nor the depth. underflow_o is 1 for exactly the one cycle after that edge.
- R8: Command code 2'b00 (idle) leaves the mask and the depth unchanged, and both flags are low after the edge.
- R9: Regions nested up to DEPTH levels give back each enclosing mask in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | 00 idle, 01 push, 10 complement, 11 pop |
| pred_i | input | LANES | Per-lane predicate for push and complement |
| issue_i | input | 1 | An instruction is issued this cycle |
| active_mask_o | output | LANES | Current active-lane mask |
| exec_o | output | LANES | Per-lane execute enable for the issued instruction |
| depth_o | output | clog2(DEPTH+1) | Number of saved masks |
| overflow_o | output | 1 | Push was refused on a full store (one-cycle pulse) |
| underflow_o | output | 1 | Pop or complement was refused on an empty store (one-cycle pulse) |

## Verification
An instruction issue and a mask command can land in the same cycle. The lane enables for that instruction must come from the mask before the command, and the new mask must show only after the edge. The bench issues on most steps of a directed nesting sequence and of a long random command stream, and it checks the enables in the middle of the cycle against the mask its model held before the step. It checks the mask, depth and flags after the edge against the model's updated state.

// File: rtl/lms_pkg.sv
package lms_pkg;

    localparam int LMS_LANES_DEF = 32;
    localparam int LMS_DEPTH_DEF = 8;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_PUSH = 2'b01,
        CMD_FLIP = 2'b10,
        CMD_POP  = 2'b11
    } lms_cmd_e;

endpackage

// File: rtl/lms_store.sv
module lms_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LANES-1:0] rd_data
);
    logic [LANES-1:0] entry_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_idx == IDX_W'(i)) entry_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == IDX_W'(i)) rd_data = entry_q[i];
    end
endmodule

// File: rtl/lms_ctrl.sv
module lms_ctrl
    import lms_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  lms_cmd_e         cmd,
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] top_mask,
    output logic             save_en,
    output logic [IDX_W-1:0] save_idx,
    output logic [IDX_W-1:0] top_idx,
    output logic [LANES-1:0] mask,
    output logic [PTR_W-1:0] depth,
    output logic             ovf,
    output logic             unf
);
    logic [LANES-1:0] mask_n;
    logic [PTR_W-1:0] depth_n;
    logic [PTR_W-1:0] depth_m1;
    logic             ovf_n, unf_n;
    logic             full, empty;

    assign full     = (depth == PTR_W'(DEPTH));
    assign empty    = (depth == '0);
    assign depth_m1 = depth - 1'b1;
    assign top_idx  = depth_m1[IDX_W-1:0];
    assign save_idx = depth[IDX_W-1:0];

    always_comb begin
        mask_n  = mask;
        depth_n = depth;
        save_en = 1'b0;
        ovf_n   = 1'b0;
        unf_n   = 1'b0;
        unique case (cmd)
            CMD_PUSH: begin
                if (full) begin
                    ovf_n = 1'b1;
                end else begin
                    save_en = 1'b1;
                    mask_n  = mask & pred;
                    depth_n = depth + 1'b1;
                end
            end
            CMD_FLIP: begin
                if (empty) unf_n = 1'b1;
                else       mask_n = top_mask & ~pred;
            end
            CMD_POP: begin
                if (empty) begin
                    unf_n = 1'b1;
                end else begin
                    mask_n  = top_mask;
                    depth_n = depth_m1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '1;
            depth <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            mask  <= mask_n;
            depth <= depth_n;
            ovf   <= ovf_n;
            unf   <= unf_n;
        end
    end
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
    import lms_pkg::*;
#(
    parameter int LANES = LMS_LANES_DEF,
    parameter int DEPTH = LMS_DEPTH_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   cmd_i,
    input  logic [LANES-1:0]             pred_i,
    input  logic                         issue_i,
    output logic [LANES-1:0]             active_mask_o,
    output logic [LANES-1:0]             exec_o,
    output logic [$clog2(DEPTH+1)-1:0]   depth_o,
    output logic                         overflow_o,
    output logic                         underflow_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lms_cmd_e         cmd;
    logic             save_en;
    logic [IDX_W-1:0] save_idx, top_idx;
    logic [LANES-1:0] top_mask;

    assign cmd = lms_cmd_e'(cmd_i);

    lms_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .pred     (pred_i),
        .top_mask (top_mask),
        .save_en  (save_en),
        .save_idx (save_idx),
        .top_idx  (top_idx),
        .mask     (active_mask_o),
        .depth    (depth_o),
        .ovf      (overflow_o),
        .unf      (underflow_o)
    );

    lms_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (save_en),
        .wr_idx  (save_idx),
        .wr_data (active_mask_o),
        .rd_idx  (top_idx),
        .rd_data (top_mask)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign exec_o[l] = issue_i & active_mask_o[l];
    end
endmodule

// File: rtl/lane_mask_stack_chk.sv
module lane_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 cmd_i,
    input logic [LANES-1:0]           pred_i,
    input logic                       issue_i,
    input logic [LANES-1:0]           active_mask_o,
    input logic [LANES-1:0]           exec_o,
    input logic [$clog2(DEPTH+1)-1:0] depth_o,
    input logic                       overflow_o,
    input logic                       underflow_o
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (active_mask_o == '1 && depth_o == '0 && !overflow_o && !underflow_o));

    a_r2_exec_gating: assert property (@(posedge clk) disable iff (rst)
        ((exec_o & ~active_mask_o) == '0) && (issue_i || exec_o == '0));

    a_r3_push_narrows: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b01 && depth_o != PTR_W'(DEPTH)) |=>
        ((active_mask_o & ~$past(active_mask_o)) == '0 &&
         depth_o == PTR_W'($past(depth_o) + 1'b1)));

    a_r4_flip_excludes_pred: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b10 && depth_o != '0) |=>
        ((active_mask_o & $past(pred_i)) == '0 && $stable(depth_o)));

    a_r5_pop_depth: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b11 && depth_o != '0) |=> depth_o == PTR_W'($past(depth_o) - 1'b1));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b01 && depth_o == PTR_W'(DEPTH)) |=>
        (overflow_o && $stable(active_mask_o) && $stable(depth_o)));

    a_r7_underflow: assert property (@(posedge clk) disable iff (rst)
        (cmd_i[1] && depth_o == '0) |=>
        (underflow_o && $stable(active_mask_o) && $stable(depth_o)));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 2'b00) |=>
        ($stable(active_mask_o) && $stable(depth_o) && !overflow_o && !underflow_o));

    a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(overflow_o && underflow_o));
endmodule

bind lane_mask_stack lane_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/lane_mask_stack_bench.sv
module lane_mask_stack_bench;
    localparam int LANES = 32;
    localparam int DEPTH = 8;
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cmd_i = 2'b00;
    logic [LANES-1:0] pred_i = '0;
    logic             issue_i = 1'b0;
    logic [LANES-1:0] active_mask_o, exec_o;
    logic [PTR_W-1:0] depth_o;
    logic             overflow_o, underflow_o;

    always #10 clk = ~clk;

    lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_lane_mask_stack (.*);

    typedef struct {
        logic [LANES-1:0] exp_exec;
        logic [LANES-1:0] exp_mask;
        int               exp_depth;
        bit               exp_ovf;
        bit               exp_unf;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [LANES-1:0] m_stk [DEPTH];
    logic [LANES-1:0] m_mask = '1;
    int               m_depth = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic [1:0] c, logic [LANES-1:0] p, bit iss, string tag);
        exp_t e;
        @(negedge clk);
        cmd_i = c; pred_i = p; issue_i = iss;
        e.exp_exec = iss ? m_mask : '0;
        e.exp_ovf = 0; e.exp_unf = 0; e.tag = tag;
        case (c)
            2'b01: if (m_depth == DEPTH) e.exp_ovf = 1;
                   else begin m_stk[m_depth] = m_mask; m_mask = m_mask & p; m_depth++; end
            2'b10: if (m_depth == 0) e.exp_unf = 1;
                   else m_mask = m_stk[m_depth-1] & ~p;
            2'b11: if (m_depth == 0) e.exp_unf = 1;
                   else begin m_mask = m_stk[m_depth-1]; m_depth--; end
            default: ;
        endcase
        e.exp_mask = m_mask; e.exp_depth = m_depth;
        q.push_back(e);
    endtask

    // monitor: exec mid-cycle (R2), state after the edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk({"R2 exec ", e.tag}, 64'(exec_o), 64'(e.exp_exec));
                @(posedge clk);
                #5;
                chk({"mask ", e.tag}, 64'(active_mask_o), 64'(e.exp_mask));
                chk({"depth ", e.tag}, 64'(depth_o), 64'(e.exp_depth));
                chk({"R6 overflow ", e.tag}, 64'(overflow_o), 64'(e.exp_ovf));
                chk({"R7 underflow ", e.tag}, 64'(underflow_o), 64'(e.exp_unf));
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mask", 64'(active_mask_o), 64'({LANES{1'b1}}));
        chk("R1 depth", 64'(depth_o), 64'd0);
        chk("R1 flags", 64'({overflow_o, underflow_o}), 64'd0);

        step(2'b00, 32'hDEAD_BEEF, 1, "R8 idle");
        step(2'b00, 32'h1234_5678, 0, "R2 no issue");
        // single if/else
        step(2'b01, 32'h0000_FFFF, 1, "R3 push");
        step(2'b10, 32'h0000_FFFF, 1, "R4 complement");
        step(2'b11, 32'h0, 1, "R5 pop");
        // nested regions
        step(2'b01, 32'h00FF_00FF, 1, "R9 outer push");
        step(2'b01, 32'h0F0F_0F0F, 1, "R9 inner push");
        step(2'b10, 32'h0F0F_0F0F, 1, "R9 inner complement");
        step(2'b11, 32'h0, 1, "R9 inner pop");
        step(2'b10, 32'h00FF_00FF, 1, "R9 outer complement");
        step(2'b11, 32'h0, 0, "R9 outer pop");
        // fill, overflow, drain, underflow
        for (int i = 0; i < DEPTH; i++)
            step(2'b01, ~(32'h1 << i), 1, "R9 fill");
        step(2'b01, 32'h0, 1, "R6 push full");
        step(2'b00, 32'h0, 1, "R6 pulse ends");
        for (int i = 0; i < DEPTH; i++)
            step(2'b11, 32'h0, 1, "R9 drain");
        step(2'b11, 32'h0, 1, "R7 pop empty");
        step(2'b10, 32'hFFFF_0000, 1, "R7 complement empty");
        step(2'b00, 32'h0, 1, "R7 pulse ends");
        // random stream
        for (int i = 0; i < 400; i++)
            step(2'($urandom_range(0, 3)), $urandom, 1'($urandom_range(0, 1)), "R3 R4 R5 random");
        wait (q.size() == 0);
        @(posedge clk);
        #10;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule